// File: doc/BRIEF.md
# Password Complexity Rule Checker

This block judges a candidate password against a fixed complexity policy. The characters arrive one per beat on a byte stream. A start marker opens a password and a last marker closes it. While the characters stream in, each one is sorted into one of five classes: uppercase letter, lowercase letter, decimal digit, special symbol, or invalid byte. A sticky presence flag is kept for each class, and a saturating counter tracks the length.

On the cycle after the last character, the block emits a single verdict pulse. The pulse carries an accept bit and one failure flag per rule, so the caller can report exactly which rule was broken. The block holds no password storage and does no hashing. It is always ready to take a new start marker, including in the verdict cycle itself.

The control is a three-state machine:
- `ST_IDLE`: waiting for a start.
- `ST_GATHER`: a password is open.
- `ST_REPORT`: the verdict cycle.

Transitions:
- A start beat without a last marker goes to `ST_GATHER`.
- Any accepted beat carrying the last marker goes to `ST_REPORT`.
- `ST_GATHER` stays in `ST_GATHER` while beats arrive or gaps occur.
- `ST_REPORT` falls back to `ST_IDLE`, unless a new beat is accepted in that same cycle.

Top module: `pwd_policy_checker`

## Requirements
- R1: After reset `verdict_valid` is 0 and all verdict outputs are 0.
- R2: `verdict_valid` is high for exactly one cycle, namely the cycle after the accepted beat carrying `in_last`. A beat with both `in_first` and `in_last` is a one-character password.
- R3: `fail_short` is set when the password holds fewer than MIN_LEN (default 8) characters.
- R4: `fail_long` is set when the password holds more than MAX_LEN (default 16) characters. The length count saturates at MAX_LEN+1, so any longer input still fails.
- R5: `fail_upper` is set when no byte in 0x41..0x5A was seen.
- R6: `fail_lower` is set when no byte in 0x61..0x7A was seen.
- R7: `fail_digit` is set when no byte in 0x30..0x39 was seen.
- R8: `fail_special` is set when no byte in 0x21..0x7E outside the three ranges above was seen.
- R9: Any byte outside 0x21..0x7E sets `fail_invalid`. Such a byte counts toward length but does not count as special.
- R10: A beat with `in_valid` low, or a beat arriving outside an open password without `in_first`, is ignored. Outside the verdict cycle all fail flags and `verdict_ok` are 0.
- R11: `in_first` while a password is open discards everything gathered so far and starts again with that beat.
- R12: `verdict_ok` is 1 exactly when `verdict_valid` is 1 and no fail flag is set.
- R13: A start beat presented in the verdict cycle is accepted and begins the next password.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier for the character stream |
| in_byte | input | 8 | Character code |
| in_first | input | 1 | Beat is the first character of a password |
| in_last | input | 1 | Beat is the final character of a password |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict_ok | output | 1 | Password meets every rule |
| fail_short | output | 1 | Fewer than MIN_LEN characters |
| fail_long | output | 1 | More than MAX_LEN characters |
| fail_upper | output | 1 | No uppercase letter |
| fail_lower | output | 1 | No lowercase letter |
| fail_digit | output | 1 | No digit |
| fail_special | output | 1 | No special symbol |
| fail_invalid | output | 1 | At least one byte outside the printable range |

## Verification
The bench builds the block with its default lengths, MIN_LEN=8 and MAX_LEN=16. This keeps both edges of the legal window (7/8 and 16/17 characters) within a few dozen beats. A 300-character stream drives the counter far past its saturation value of 17, which checks that a wrapped count can never look legal. One-character passwords, restarts in mid-password, gaps with `in_valid` low, and a start beat landing in the verdict cycle exercise each transition of the state machine.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    localparam int NUM_CLS = 5;
    localparam int CLS_UP  = 0;
    localparam int CLS_LO  = 1;
    localparam int CLS_DIG = 2;
    localparam int CLS_SPC = 3;
    localparam int CLS_BAD = 4;

    localparam logic [7:0] PRINT_LO = 8'h21;
    localparam logic [7:0] PRINT_HI = 8'h7E;
    localparam logic [7:0] UP_LO    = 8'h41;
    localparam logic [7:0] UP_HI    = 8'h5A;
    localparam logic [7:0] LO_LO    = 8'h61;
    localparam logic [7:0] LO_HI    = 8'h7A;
    localparam logic [7:0] DIG_LO   = 8'h30;
    localparam logic [7:0] DIG_HI   = 8'h39;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GATHER = 2'd1,
        ST_REPORT = 2'd2
    } chk_state_t;
endpackage

// File: rtl/pwd_char_class.sv
module pwd_char_class
    import pwd_pkg::*;
(
    input  logic [7:0]         code,
    output logic [NUM_CLS-1:0] hit
);
    logic is_up, is_lo, is_dig, is_print;

    always_comb begin
        is_up    = (code >= UP_LO)    && (code <= UP_HI);
        is_lo    = (code >= LO_LO)    && (code <= LO_HI);
        is_dig   = (code >= DIG_LO)   && (code <= DIG_HI);
        is_print = (code >= PRINT_LO) && (code <= PRINT_HI);
        hit          = '0;
        hit[CLS_UP]  = is_up;
        hit[CLS_LO]  = is_lo;
        hit[CLS_DIG] = is_dig;
        hit[CLS_SPC] = is_print && !is_up && !is_lo && !is_dig;
        hit[CLS_BAD] = !is_print;
    end
endmodule

// File: rtl/pwd_len_count.sv
module pwd_len_count #(
    parameter int MAX_LEN = 16,
    localparam int SAT    = MAX_LEN + 1,
    localparam int CNT_W  = $clog2(SAT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(1);
        end else if (step) begin
            if (cnt != CNT_W'(SAT)) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    p_sat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(SAT));
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && cnt == CNT_W'(SAT)) |=> cnt == CNT_W'(SAT));
endmodule

// File: rtl/pwd_class_flags.sv
module pwd_class_flags
    import pwd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               step,
    input  logic [NUM_CLS-1:0] hit,
    output logic [NUM_CLS-1:0] seen
);
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seen[g] <= 1'b0;
            end else if (restart) begin
                seen[g] <= hit[g];
            end else if (step && hit[g]) begin
                seen[g] <= 1'b1;
            end
        end
    end

    p_class_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> $onehot(hit));
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(seen));
endmodule

// File: rtl/pwd_policy_checker.sv
module pwd_policy_checker
    import pwd_pkg::*;
#(
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 16,
    localparam int CNT_W  = $clog2(MAX_LEN + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_first,
    input  logic       in_last,
    output logic       verdict_valid,
    output logic       verdict_ok,
    output logic       fail_short,
    output logic       fail_long,
    output logic       fail_upper,
    output logic       fail_lower,
    output logic       fail_digit,
    output logic       fail_special,
    output logic       fail_invalid
);
    chk_state_t state, state_nx;
    logic take, restart, step;
    logic [NUM_CLS-1:0] hit, seen;
    logic [CNT_W-1:0] len;

    always_comb begin
        restart = in_valid && in_first;
        take    = restart || (in_valid && state == ST_GATHER);
        step    = take && !restart;
    end

    pwd_char_class u_cls (
        .code (in_byte),
        .hit  (hit)
    );

    pwd_len_count #(.MAX_LEN(MAX_LEN)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (step),
        .cnt     (len)
    );

    pwd_class_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (step),
        .hit     (hit),
        .seen    (seen)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_REPORT: begin
                if (take && in_last)  state_nx = ST_REPORT;
                else if (take)        state_nx = ST_GATHER;
                else                  state_nx = ST_IDLE;
            end
            ST_GATHER: begin
                if (take && in_last)  state_nx = ST_REPORT;
                else                  state_nx = ST_GATHER;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        logic rep;
        rep           = (state == ST_REPORT);
        verdict_valid = rep;
        fail_short    = rep && (len < CNT_W'(MIN_LEN));
        fail_long     = rep && (len > CNT_W'(MAX_LEN));
        fail_upper    = rep && !seen[CLS_UP];
        fail_lower    = rep && !seen[CLS_LO];
        fail_digit    = rep && !seen[CLS_DIG];
        fail_special  = rep && !seen[CLS_SPC];
        fail_invalid  = rep && seen[CLS_BAD];
        verdict_ok    = rep && !(fail_short || fail_long || fail_upper ||
                        fail_lower || fail_digit || fail_special || fail_invalid);
    end

    p_pulse_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_valid |-> $past(in_valid && in_last));
    p_ok_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_ok |-> (verdict_valid && !fail_short && !fail_long && !fail_upper &&
                        !fail_lower && !fail_digit && !fail_special && !fail_invalid));
    p_quiet_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_valid |-> !(verdict_ok || fail_short || fail_long || fail_upper ||
                             fail_lower || fail_digit || fail_special || fail_invalid));
    p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail_short && fail_long));
endmodule

// File: tb/sim_pwd_policy_checker.sv
module sim_pwd_policy_checker;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_first = 1'b0;
    logic in_last = 1'b0;
    logic verdict_valid, verdict_ok, fail_short, fail_long, fail_upper;
    logic fail_lower, fail_digit, fail_special, fail_invalid;

    int total = 0;
    int bad = 0;
    logic [7:0] pw [0:511];
    int pw_len = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwd_policy_checker u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_first(in_first), .in_last(in_last), .verdict_valid(verdict_valid),
        .verdict_ok(verdict_ok), .fail_short(fail_short), .fail_long(fail_long),
        .fail_upper(fail_upper), .fail_lower(fail_lower), .fail_digit(fail_digit),
        .fail_special(fail_special), .fail_invalid(fail_invalid)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [8:0] outs();
        return {verdict_valid, verdict_ok, fail_short, fail_long, fail_upper,
                fail_lower, fail_digit, fail_special, fail_invalid};
    endfunction

    function automatic logic [8:0] expect_of(input int n);
        logic up = 0, lo = 0, dg = 0, sp = 0, iv = 0;
        logic s, l, ok;
        for (int i = 0; i < n; i++) begin
            if (pw[i] >= 8'h41 && pw[i] <= 8'h5A) up = 1;
            else if (pw[i] >= 8'h61 && pw[i] <= 8'h7A) lo = 1;
            else if (pw[i] >= 8'h30 && pw[i] <= 8'h39) dg = 1;
            else if (pw[i] >= 8'h21 && pw[i] <= 8'h7E) sp = 1;
            else iv = 1;
        end
        s  = (n < 8);
        l  = (n > 16);
        ok = !(s || l || !up || !lo || !dg || !sp || iv);
        return {1'b1, ok, s, l, !up, !lo, !dg, !sp, iv};
    endfunction

    task automatic load(input string s);
        pw_len = s.len();
        for (int i = 0; i < s.len(); i++) pw[i] = s[i];
    endtask

    // Drives pw[0..pw_len-1]; returns at the negedge after the final beat.
    task automatic drive(input bit with_last, input bit gaps);
        for (int i = 0; i < pw_len; i++) begin
            in_valid = 1'b1;
            in_byte  = pw[i];
            in_first = (i == 0);
            in_last  = with_last && (i == pw_len - 1);
            @(negedge clk);
            if (gaps && i != pw_len - 1) begin
                in_valid = 1'b0;
                in_byte  = 8'h20;
                in_first = 1'b1;
                in_last  = 1'b1;
                @(negedge clk);
            end
        end
    endtask

    task automatic go_idle();
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_byte = 8'h00;
    endtask

    task automatic run_case(input string req, input string s, input bit gaps);
        load(s);
        drive(1'b1, gaps);
        check(req, outs(), expect_of(pw_len));
        go_idle();
        @(negedge clk);
        check({req, " R2 pulse ends"}, {8'h00, verdict_valid}, 9'd0);
    endtask

    task automatic t_reset();
        check("R1 reset", outs(), 9'd0);
    endtask

    task automatic t_lengths();
        run_case("R12 accept len 8", "Abcdef1!", 0);
        run_case("R3 short len 7", "Abcde1!", 0);
        run_case("R4 ok len 16", "Abcdefgh1234!@#x", 0);
        run_case("R4 long len 17", "Abcdefgh1234!@#xy", 0);
        run_case("R2 single char", "A", 0);
    endtask

    task automatic t_saturate();
        pw_len = 300;
        for (int i = 0; i < 300; i++) pw[i] = 8'h61 + 8'(i % 26);
        pw[5] = "Q"; pw[9] = "7"; pw[11] = "#";
        drive(1'b1, 0);
        check("R4 saturate 300", outs(), expect_of(300));
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_classes();
        run_case("R5 no upper", "abcdef1!", 0);
        run_case("R6 no lower", "ABCDEF1!", 0);
        run_case("R7 no digit", "Abcdefg!", 0);
        run_case("R8 no special", "Abcdefg1", 0);
        run_case("R8 special edge ~ and [", "Abcdef1~", 0);
        run_case("R8 special bracket", "Abcdef1[", 0);
    endtask

    task automatic t_invalid();
        run_case("R9 space inside", "Abc def1!", 0);
        load("Abcdef1");
        pw[7] = 8'h7F; pw_len = 8;
        drive(1'b1, 0);
        check("R9 DEL byte not special", outs(), expect_of(8));
        go_idle();
        @(negedge clk);
    endtask

    task automatic t_ignore();
        in_valid = 1'b1; in_byte = 8'h20; in_first = 1'b0; in_last = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 stray beats ignored", outs(), 9'd0);
        go_idle();
        run_case("R10 gaps ignored", "Xyz12#ab", 1);
    endtask

    task automatic t_restart();
        load("ab  c");
        drive(1'b0, 0);
        run_case("R11 restart discards", "Zq9!Zq9!", 0);
    endtask

    task automatic t_back_to_back();
        load("Abcdef1!");
        drive(1'b1, 0);
        check("R13 first verdict", outs(), expect_of(8));
        load("abc");
        drive(1'b1, 0);
        check("R13 second verdict", outs(), expect_of(3));
        go_idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_lengths();
        t_saturate();
        t_classes();
        t_invalid();
        t_ignore();
        t_restart();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule